// File: doc/BRIEF.md
# Sharer-Tracking Directory Home Node

This block is the home node for a small set of cache lines shared by several cores. For each line it holds a coherence state (uncached, shared, or owned exclusively by one core), a bit-vector of the cores that hold a copy, the owning core's index, and one word of memory copy. Cores send it read or write misses and write upgrades. It answers each one with a permission grant (shared, exclusive-clean or modified) and the current memory word.

When other cores hold the line, the block sends a coherence message only to the cores it has recorded as holders. A write to a shared line invalidates the other sharers. A request to a line owned by another core either fetches the data from the owner (on a read) or invalidates the owner (on a write). The block holds the grant until every targeted sharer has acknowledged, or until the owner has returned its data through a write-back. While a line waits for these replies, requests to that line are held off and requests to other lines go ahead.

An owner can also write back a line on its own, without being asked. That write-back updates the memory word and returns the line to the uncached state.

Top module: `dirc_home`

## Requirements
- R1: After reset every line is uncached with memory word 0, no grant or message is issued, and `req_ready` is high.
- R2: A read to an uncached line grants exclusive-clean (perm code 2) with the memory word on the cycle after acceptance, and the requester becomes owner.
- R3: A read to a shared line grants shared (perm code 1) on the next cycle with no message, and the requester is added to the sharers.
- R4: A write to a shared line sends, on the next cycle, one invalidate message (kind code 0) whose target mask holds exactly the sharers other than the requester (bit i = core i); three sharers and a sharer writing give exactly two mask bits.
- R5: The modified grant (perm code 3) for a write that sent invalidations is issued on the cycle after the last of as many acknowledgements as mask bits sent, and not earlier.
- R6: A read to a line owned by another core sends a fetch message (kind code 1) to the owner only. When the owner's write-back arrives, the memory word takes its data and shared is granted with that data on the next cycle. Owner and requester both become sharers.
- R7: A write to a line owned by another core sends an invalidate message to the owner only. The owner's write-back data becomes the memory word and is granted modified to the requester on the following cycle.
- R8: A write-back from the owner of a line that is not waiting for replies updates the memory word, leaves the line uncached, and issues no grant.
- R9: While a line awaits replies, `req_ready` is low for requests to that line, and requests to other lines are accepted.
- R10: In any cycle with `ack_valid` or `wb_valid` high, `req_ready` is low and no request is taken. Grant and message outputs never pulse together.
- R11: A request from the line's current owner is granted at once with no message: modified for a write, exclusive-clean for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request taken at this edge |
| req_core | input | CW | Requesting core index |
| req_line | input | LW | Line index |
| req_wr | input | 1 | 1 = write/upgrade, 0 = read |
| ack_valid | input | 1 | Invalidation acknowledgement |
| ack_line | input | LW | Line being acknowledged |
| wb_valid | input | 1 | Owner write-back or flush |
| wb_line | input | LW | Line written back |
| wb_data | input | DW | Written-back word |
| msg_valid | output | 1 | Coherence message pulse |
| msg_kind | output | 1 | 0 = invalidate, 1 = fetch and downgrade |
| msg_line | output | LW | Line of the message |
| msg_mask | output | NCORES | Target cores, one bit per core |
| grant_valid | output | 1 | Permission grant pulse |
| grant_core | output | CW | Core receiving the grant |
| grant_line | output | LW | Granted line |
| grant_perm | output | 2 | 1 shared, 2 exclusive-clean, 3 modified |
| grant_data | output | DW | Memory word supplied with the grant |

## Verification
The bench targets the case of three sharers where one of them writes. A design that broadcast invalidations, or that included the writer in the targets, would show an extra mask bit and would wait for an acknowledgement that never comes. It also sends acknowledgements one at a time to catch a grant issued one acknowledgement early. It sends requests to a line that is waiting for replies, and sends a response and a request in the same cycle, to check that the stall and the response priority hold while other lines keep moving. Fetch and unsolicited write-backs carry distinct data words, so a design that granted stale memory, or that did not clear ownership on eviction, returns the wrong word or the wrong permission.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
    typedef enum logic [1:0] {
        LN_UNC = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } ln_state_e;

    localparam logic [1:0] PERM_S = 2'd1;
    localparam logic [1:0] PERM_E = 2'd2;
    localparam logic [1:0] PERM_M = 2'd3;

    localparam logic MSG_INV   = 1'b0;
    localparam logic MSG_FETCH = 1'b1;
endpackage

// File: rtl/dirc_popcount.sv
module dirc_popcount #(
    parameter int W  = 4,
    parameter int OW = 3
) (
    input  logic [W-1:0]  vec,
    output logic [OW-1:0] cnt
);
    logic [OW-1:0] part [W+1];

    assign part[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_sum
        assign part[i+1] = part[i] + OW'(vec[i]);
    end
    assign cnt = part[W];
endmodule

// File: rtl/dirc_target_sel.sv
module dirc_target_sel
    import dirc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int CW     = 2
) (
    input  ln_state_e          st,
    input  logic [NCORES-1:0]  sharers,
    input  logic [CW-1:0]      owner,
    input  logic [CW-1:0]      req_core,
    output logic [NCORES-1:0]  targets
);
    logic [NCORES-1:0] req_bit;
    logic [NCORES-1:0] own_bit;

    for (genvar i = 0; i < NCORES; i++) begin : g_dec
        assign req_bit[i] = (req_core == CW'(i));
        assign own_bit[i] = (owner == CW'(i));
    end

    always_comb begin
        targets = '0;
        if (st == LN_SHR) begin
            targets = sharers & ~req_bit;
        end else if (st == LN_EXC && owner != req_core) begin
            targets = own_bit;
        end
    end
endmodule

// File: rtl/dirc_home.sv
module dirc_home
    import dirc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 4,
    parameter int DW     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [$clog2(NCORES)-1:0]  req_core,
    input  logic [$clog2(NLINES)-1:0]  req_line,
    input  logic                       req_wr,
    input  logic                       ack_valid,
    input  logic [$clog2(NLINES)-1:0]  ack_line,
    input  logic                       wb_valid,
    input  logic [$clog2(NLINES)-1:0]  wb_line,
    input  logic [DW-1:0]              wb_data,
    output logic                       msg_valid,
    output logic                       msg_kind,
    output logic [$clog2(NLINES)-1:0]  msg_line,
    output logic [NCORES-1:0]          msg_mask,
    output logic                       grant_valid,
    output logic [$clog2(NCORES)-1:0]  grant_core,
    output logic [$clog2(NLINES)-1:0]  grant_line,
    output logic [1:0]                 grant_perm,
    output logic [DW-1:0]              grant_data
);
    localparam int CW   = $clog2(NCORES);
    localparam int LW   = $clog2(NLINES);
    localparam int CNTW = $clog2(NCORES + 1);
    localparam logic [NCORES-1:0] ONE = NCORES'(1);

    typedef struct packed {
        ln_state_e          st;
        logic [NCORES-1:0]  sh;
        logic [CW-1:0]      own;
        logic               busy;
        logic               wfb;   // waiting for owner write-back
        logic               pw;    // pending request is a write
        logic [CW-1:0]      pc;    // pending requester
        logic [CNTW-1:0]    cnt;   // outstanding acks
        logic [DW-1:0]      mem;
    } line_t;

    typedef struct packed {
        line_t [NLINES-1:0] ln;
        logic               gv;
        logic [CW-1:0]      gc;
        logic [LW-1:0]      gl;
        logic [1:0]         gp;
        logic [DW-1:0]      gd;
        logic               mv;
        logic               mk;
        logic [LW-1:0]      ml;
        logic [NCORES-1:0]  mm;
    } state_t;

    state_t s_q, s_d;
    line_t  cur_q;
    logic [NCORES-1:0] tgt;
    logic [CNTW-1:0]   tgt_cnt;

    assign cur_q = s_q.ln[req_line];

    dirc_target_sel #(.NCORES(NCORES), .CW(CW)) u_tsel (
        .st       (cur_q.st),
        .sharers  (cur_q.sh),
        .owner    (cur_q.own),
        .req_core (req_core),
        .targets  (tgt)
    );

    dirc_popcount #(.W(NCORES), .OW(CNTW)) u_pop (
        .vec (tgt),
        .cnt (tgt_cnt)
    );

    assign req_ready = !ack_valid && !wb_valid && !cur_q.busy;

    always_comb begin
        s_d    = s_q;
        s_d.gv = 1'b0;
        s_d.mv = 1'b0;

        // owner write-back: solicited reply or unsolicited eviction
        if (wb_valid) begin
            if (s_q.ln[wb_line].busy && s_q.ln[wb_line].wfb) begin
                s_d.ln[wb_line].mem  = wb_data;
                s_d.ln[wb_line].busy = 1'b0;
                s_d.ln[wb_line].wfb  = 1'b0;
                s_d.gv = 1'b1;
                s_d.gc = s_q.ln[wb_line].pc;
                s_d.gl = wb_line;
                s_d.gd = wb_data;
                if (s_q.ln[wb_line].pw) begin
                    s_d.ln[wb_line].st  = LN_EXC;
                    s_d.ln[wb_line].own = s_q.ln[wb_line].pc;
                    s_d.ln[wb_line].sh  = ONE << s_q.ln[wb_line].pc;
                    s_d.gp = PERM_M;
                end else begin
                    s_d.ln[wb_line].st = LN_SHR;
                    s_d.ln[wb_line].sh = (ONE << s_q.ln[wb_line].own)
                                       | (ONE << s_q.ln[wb_line].pc);
                    s_d.gp = PERM_S;
                end
            end else if (!s_q.ln[wb_line].busy && s_q.ln[wb_line].st == LN_EXC) begin
                s_d.ln[wb_line].mem = wb_data;
                s_d.ln[wb_line].st  = LN_UNC;
                s_d.ln[wb_line].sh  = '0;
            end
        end

        // invalidation acknowledgement counting
        if (ack_valid && s_q.ln[ack_line].busy && !s_q.ln[ack_line].wfb
            && s_q.ln[ack_line].cnt != '0) begin
            if (s_q.ln[ack_line].cnt == CNTW'(1)) begin
                s_d.ln[ack_line].cnt  = '0;
                s_d.ln[ack_line].busy = 1'b0;
                s_d.ln[ack_line].st   = LN_EXC;
                s_d.ln[ack_line].own  = s_q.ln[ack_line].pc;
                s_d.ln[ack_line].sh   = ONE << s_q.ln[ack_line].pc;
                s_d.gv = 1'b1;
                s_d.gc = s_q.ln[ack_line].pc;
                s_d.gl = ack_line;
                s_d.gp = PERM_M;
                s_d.gd = s_q.ln[ack_line].mem;
            end else begin
                s_d.ln[ack_line].cnt = s_q.ln[ack_line].cnt - CNTW'(1);
            end
        end

        // new request
        if (req_valid && req_ready) begin
            s_d.gc = req_core;
            s_d.gl = req_line;
            s_d.gd = cur_q.mem;
            s_d.ml = req_line;
            s_d.mm = tgt;
            if (cur_q.st == LN_UNC || (cur_q.st == LN_EXC && cur_q.own == req_core)) begin
                s_d.ln[req_line].st  = LN_EXC;
                s_d.ln[req_line].own = req_core;
                s_d.ln[req_line].sh  = ONE << req_core;
                s_d.gv = 1'b1;
                s_d.gp = req_wr ? PERM_M : PERM_E;
            end else if (cur_q.st == LN_SHR && !req_wr) begin
                s_d.ln[req_line].sh = cur_q.sh | (ONE << req_core);
                s_d.gv = 1'b1;
                s_d.gp = PERM_S;
            end else if (tgt == '0) begin
                s_d.ln[req_line].st  = LN_EXC;
                s_d.ln[req_line].own = req_core;
                s_d.ln[req_line].sh  = ONE << req_core;
                s_d.gv = 1'b1;
                s_d.gp = PERM_M;
            end else begin
                s_d.ln[req_line].busy = 1'b1;
                s_d.ln[req_line].pc   = req_core;
                s_d.ln[req_line].pw   = req_wr;
                s_d.ln[req_line].wfb  = (cur_q.st == LN_EXC);
                s_d.ln[req_line].cnt  = (cur_q.st == LN_EXC) ? '0 : tgt_cnt;
                s_d.mv = 1'b1;
                s_d.mk = (cur_q.st == LN_EXC && !req_wr) ? MSG_FETCH : MSG_INV;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign msg_valid   = s_q.mv;
    assign msg_kind    = s_q.mk;
    assign msg_line    = s_q.ml;
    assign msg_mask    = s_q.mm;
    assign grant_valid = s_q.gv;
    assign grant_core  = s_q.gc;
    assign grant_line  = s_q.gl;
    assign grant_perm  = s_q.gp;
    assign grant_data  = s_q.gd;
endmodule

// File: rtl/dirc_home_chk.sv
module dirc_home_chk
    import dirc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int NLINES = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [$clog2(NCORES)-1:0]  req_core,
    input logic [$clog2(NLINES)-1:0]  req_line,
    input logic                       ack_valid,
    input logic                       wb_valid,
    input logic                       msg_valid,
    input logic                       msg_kind,
    input logic [$clog2(NLINES)-1:0]  msg_line,
    input logic [NCORES-1:0]          msg_mask,
    input logic                       grant_valid,
    input logic [1:0]                 grant_perm
);
    localparam logic [NCORES-1:0] ONE = NCORES'(1);

    // R4
    inv_no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ($past(req_valid && req_ready)
                       && ((msg_mask & (ONE << $past(req_core))) == '0)));

    // R6
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == MSG_FETCH) |-> ($countones(msg_mask) == 1));

    // R9
    busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && req_valid && req_line == msg_line) |-> !req_ready);

    // R10
    out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid && msg_valid));

    // R5
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> $past((req_valid && req_ready) || ack_valid || wb_valid));

    // R2
    perm_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_perm != 2'd0));
endmodule

bind dirc_home dirc_home_chk #(.NCORES(NCORES), .NLINES(NLINES)) u_chk (.*);

// File: tb/dirc_home_bench.sv
module dirc_home_bench;
    localparam int NC = 4;
    localparam int NL = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_core = '0;
    logic [1:0] req_line = '0;
    logic req_wr = 1'b0;
    logic ack_valid = 1'b0;
    logic [1:0] ack_line = '0;
    logic wb_valid = 1'b0;
    logic [1:0] wb_line = '0;
    logic [DW-1:0] wb_data = '0;
    logic msg_valid, msg_kind;
    logic [1:0] msg_line;
    logic [NC-1:0] msg_mask;
    logic grant_valid;
    logic [1:0] grant_core, grant_line, grant_perm;
    logic [DW-1:0] grant_data;

    dirc_home #(.NCORES(NC), .NLINES(NL), .DW(DW)) u_dirc_home (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int mst[NL], msh[NL], mown[NL], mbusy[NL], mwfb[NL], mpw[NL], mpc[NL], mcnt[NL], mmem[NL];
    int e_g, e_m;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int gkey(int v, int c, int l, int p, int d);
        return v ? ((1 << 28) | (c << 24) | (l << 20) | (p << 16) | d) : 0;
    endfunction

    function automatic int mkey(int v, int k, int l, int m);
        return v ? ((1 << 28) | (k << 24) | (l << 20) | m) : 0;
    endfunction

    always @(posedge clk) begin
        int rv, rc, rl, rw, av, al, wv, wl, wd, rdy, l, tg, n;
        rv = req_valid; rc = req_core; rl = req_line; rw = req_wr;
        av = ack_valid; al = ack_line; wv = wb_valid; wl = wb_line; wd = wb_data;
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin
                mst[i] = 0; msh[i] = 0; mown[i] = 0; mbusy[i] = 0; mwfb[i] = 0;
                mpw[i] = 0; mpc[i] = 0; mcnt[i] = 0; mmem[i] = 0;
            end
            e_g = 0; e_m = 0;
        end else begin
            rdy = !(av || wv) && !mbusy[rl];
            e_g = 0; e_m = 0;
            if (wv) begin
                l = wl;
                if (mbusy[l] && mwfb[l]) begin
                    mmem[l] = wd; mbusy[l] = 0; mwfb[l] = 0;
                    if (mpw[l]) begin
                        mst[l] = 2; mown[l] = mpc[l]; msh[l] = 1 << mpc[l];
                        e_g = gkey(1, mpc[l], l, 3, wd);
                    end else begin
                        mst[l] = 1; msh[l] = (1 << mown[l]) | (1 << mpc[l]);
                        e_g = gkey(1, mpc[l], l, 1, wd);
                    end
                end else if (!mbusy[l] && mst[l] == 2) begin
                    mmem[l] = wd; mst[l] = 0; msh[l] = 0;
                end
            end
            if (av) begin
                l = al;
                if (mbusy[l] && !mwfb[l] && mcnt[l] > 0) begin
                    mcnt[l]--;
                    if (mcnt[l] == 0) begin
                        mbusy[l] = 0; mst[l] = 2; mown[l] = mpc[l]; msh[l] = 1 << mpc[l];
                        e_g = gkey(1, mpc[l], l, 3, mmem[l]);
                    end
                end
            end
            if (rv && rdy) begin
                l = rl;
                if (mst[l] == 0 || (mst[l] == 2 && mown[l] == rc)) begin
                    mst[l] = 2; mown[l] = rc; msh[l] = 1 << rc;
                    e_g = gkey(1, rc, l, rw ? 3 : 2, mmem[l]);
                end else if (mst[l] == 1 && !rw) begin
                    msh[l] |= (1 << rc);
                    e_g = gkey(1, rc, l, 1, mmem[l]);
                end else begin
                    tg = (mst[l] == 1) ? (msh[l] & ~(1 << rc)) : (1 << mown[l]);
                    if (tg == 0) begin
                        mst[l] = 2; mown[l] = rc; msh[l] = 1 << rc;
                        e_g = gkey(1, rc, l, 3, mmem[l]);
                    end else begin
                        n = 0;
                        for (int b = 0; b < NC; b++) n += (tg >> b) & 1;
                        mbusy[l] = 1; mpc[l] = rc; mpw[l] = rw;
                        mwfb[l] = (mst[l] == 2);
                        mcnt[l] = (mst[l] == 2) ? 0 : n;
                        e_m = mkey(1, (mst[l] == 2 && !rw) ? 1 : 0, l, tg);
                    end
                end
            end
            #3;
            chk(gkey(grant_valid, grant_core, grant_line, grant_perm, grant_data) == e_g,
                "grant", gkey(grant_valid, grant_core, grant_line, grant_perm, grant_data), e_g);
            chk(mkey(msg_valid, msg_kind, msg_line, msg_mask) == e_m,
                "msg", mkey(msg_valid, msg_kind, msg_line, msg_mask), e_m);
            rdy = !(ack_valid || wb_valid) && !mbusy[req_line];
            chk(req_ready == rdy, "ready", req_ready, rdy);
        end
    end

    task automatic send(input int c, input int l, input int w);
        @(negedge clk);
        req_valid = 1'b1; req_core = 2'(c); req_line = 2'(l); req_wr = w[0];
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ack(input int l);
        @(negedge clk);
        ack_valid = 1'b1; ack_line = 2'(l);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic wback(input int l, input int d);
        @(negedge clk);
        wb_valid = 1'b1; wb_line = 2'(l); wb_data = DW'(d);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic expect_grant(input int c, input int l, input int p, input int d);
        int a, e;
        a = gkey(grant_valid, grant_core, grant_line, grant_perm, grant_data);
        e = gkey(1, c, l, p, d);
        chk(a == e && !msg_valid, "directed grant", a, e);
    endtask

    task automatic expect_msg(input int k, input int l, input int m);
        int a, e;
        a = mkey(msg_valid, msg_kind, msg_line, msg_mask);
        e = mkey(1, k, l, m);
        chk(a == e && !grant_valid, "directed msg", a, e);
    endtask

    task automatic expect_quiet();
        chk(!grant_valid && !msg_valid, "quiet", {grant_valid, msg_valid}, 0);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            tag = "R1";
            chk(1'b0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk(req_ready == 1'b1, "ready after reset", req_ready, 1);
        expect_quiet();

        tag = "R2";
        send(0, 0, 0); expect_grant(0, 0, 2, 0);

        tag = "R6";
        send(1, 0, 0); expect_msg(1, 0, 4'b0001);
        wback(0, 'h00A0); expect_grant(1, 0, 1, 'h00A0);

        tag = "R3";
        send(2, 0, 0); expect_grant(2, 0, 1, 'h00A0);

        tag = "R4";
        send(1, 0, 1); expect_msg(0, 0, 4'b0101);

        tag = "R9";
        @(negedge clk);
        req_valid = 1'b1; req_core = 2'd3; req_line = 2'd0; req_wr = 1'b0;
        #1 chk(req_ready == 1'b0, "busy line stalls", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        expect_quiet();
        send(3, 1, 0); expect_grant(3, 1, 2, 0);

        tag = "R5";
        ack(0); expect_quiet();
        ack(0); expect_grant(1, 0, 3, 'h00A0);

        tag = "R7";
        send(2, 0, 1); expect_msg(0, 0, 4'b0010);
        wback(0, 'h0BEE); expect_grant(2, 0, 3, 'h0BEE);

        tag = "R6";
        send(3, 0, 0); expect_msg(1, 0, 4'b0100);
        wback(0, 'h1234); expect_grant(3, 0, 1, 'h1234);
        send(0, 0, 1); expect_msg(0, 0, 4'b1100);
        ack(0); ack(0); expect_grant(0, 0, 3, 'h1234);

        tag = "R8";
        wback(1, 'h5A5A); expect_quiet();
        send(0, 1, 0); expect_grant(0, 1, 2, 'h5A5A);

        tag = "R11";
        send(0, 1, 1); expect_grant(0, 1, 3, 'h5A5A);
        send(0, 1, 0); expect_grant(0, 1, 2, 'h5A5A);

        tag = "R10";
        send(1, 2, 0); expect_grant(1, 2, 2, 0);
        send(2, 2, 0); expect_msg(1, 2, 4'b0010);
        wback(2, 'h0777); expect_grant(2, 2, 1, 'h0777);
        send(3, 2, 1); expect_msg(0, 2, 4'b0110);
        @(negedge clk);
        ack_valid = 1'b1; ack_line = 2'd2;
        req_valid = 1'b1; req_core = 2'd0; req_line = 2'd3; req_wr = 1'b0;
        #1 chk(req_ready == 1'b0, "response blocks request", req_ready, 0);
        @(negedge clk);
        ack_valid = 1'b0; req_valid = 1'b0;
        expect_quiet();
        ack(2); expect_grant(3, 2, 3, 'h0777);
        send(0, 3, 0); expect_grant(0, 3, 2, 0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        report();
    end
endmodule